// File: doc/BRIEF.md
# Scan Chain Test Sequencer

This block holds a bank of state registers built as mux-D scan cells and a sequencer that runs scan tests on the logic around them. When no test is running, the registers behave as ordinary functional flops and load the next-state values that the surrounding combinational logic presents on `funcNext`. A start pulse launches a test of `patCount` patterns over a chain of `chainLen` cells.

During a test the cells are joined into one serial shift register. The sequencer first shifts the first pattern in. It then drops to functional mode for exactly one clock, so the cells capture the logic's response. After that it shifts again. On each of these later passes, the captured response leaves on `scanOut` while the next pattern enters on `scanIn`. The unloaded bits are compared with the serial expected stream `expIn` in the same cycle they appear. After the last capture, a final pass only unloads and compares. A sticky `fail` flag records any mismatch, and a one-cycle `done` pulse marks the end of the run.

The external tester watches `testMode`. While it is high, the tester presents one stimulus bit and one expected bit per clock.

Top module: `scan_test_ctrl`

## Requirements
- R1: While reset is held and right after it is released, `testMode`, `done` and `fail` are all 0.
- R2: While no test runs (`testMode` low), every register loads its `funcNext` bit on each clock edge.
- R3: A start pulse with `patCount` >= 1, seen while idle, raises `testMode` in the next cycle. In every cycle with `testMode` high, the edge moves `scanIn` into cell 0 and cell i-1 into cell i. `scanOut` always shows cell `chainLen`-1. A pattern therefore enters last bit first, and a response leaves with cell `chainLen`-1 first.
- R4: Between two shift passes, `testMode` is low for exactly one cycle. On that edge every register captures `funcNext`.
- R5: Every shift pass lasts exactly `chainLen` cycles. Each pass after a capture unloads the captured response while it loads the next pattern.
- R6: The first shift pass of a test compares nothing. A mismatch on `expIn` during that pass never sets `fail`.
- R7: In every later pass, including the final unload, a cycle with `scanOut` != `expIn` sets `fail` from the next cycle on. `fail` stays set until the next accepted start clears it.
- R8: `done` is a single-cycle pulse. It comes in the cycle right after the final unload, which is P*(L+1)+L+1 cycles after the start edge for P patterns and chain length L.
- R9: A start pulse is ignored while a test is running. A start pulse with `patCount` = 0 is also ignored: the block stays idle and `fail` keeps its value.
- R10: `chainLen` selects the active chain length (1 to MAX_LEN). Shorter chains shift, capture and compare correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse for a test run |
| chainLen | input | LEN_W | Active chain length, 1 to MAX_LEN |
| patCount | input | PAT_W | Number of patterns in the run |
| scanIn | input | 1 | Serial pattern bit, taken on each shift cycle |
| expIn | input | 1 | Serial expected bit for the current `scanOut` |
| funcNext | input | MAX_LEN | Functional next-state values from the logic under test |
| regQ | output | MAX_LEN | Register contents, feeding the logic under test |
| testMode | output | 1 | High while the chain shifts |
| scanOut | output | 1 | Serial output, taken from cell `chainLen`-1 |
| fail | output | 1 | Sticky mismatch flag |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
On every overlapped pass, the block unloads and compares a captured response in the same cycle that it loads the next pattern bit. If either side is off by one bit position, the two streams corrupt each other. The scoreboard derives every unloaded bit from its own model of the logic applied to the previous pattern. It also feeds a deliberately wrong expected bit once, so the timing of the `fail` rise is checked against that exact cycle. A start pulse is also injected mid-run, so that a busy start arrives alongside an active shift. It is judged by the unchanged `done` timing and the intact scan stream.

// File: rtl/scan_pkg.sv
package scan_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_CAPTURE,
    ST_UNLOAD
  } seqState_t;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic shift;      // cells in serial mode
    logic compare;    // check scanOut against expIn this cycle
    logic clearFail;  // accepted start: clear sticky flag
  } scanStrobe_t;

endpackage

// File: rtl/scan_cell.sv
module scan_cell (
  input  logic clk,
  input  logic rstN,
  input  logic testSel,
  input  logic funcD,
  input  logic scanD,
  output logic q
);

  logic dSel;

  always_comb begin
    dSel = testSel ? scanD : funcD;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) q <= 1'b0;
    else       q <= dSel;
  end

endmodule

// File: rtl/scan_datapath.sv
module scan_datapath
  import scan_pkg::*;
#(
  parameter int MAX_LEN = 16,
  parameter int LEN_W   = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  scanStrobe_t        strobe,
  input  logic [LEN_W-1:0]   chainLen,
  input  logic               scanIn,
  input  logic               expIn,
  input  logic [MAX_LEN-1:0] funcNext,
  output logic [MAX_LEN-1:0] regQ,
  output logic               scanOut,
  output logic               fail
);

  // Build the chain: cell 0 is fed from scanIn, every other cell from the one before it
  for (genvar i = 0; i < MAX_LEN; i++) begin : g_cell
    if (i == 0) begin : g_head
      scan_cell u_cell (
        .clk    (clk),
        .rstN   (rstN),
        .testSel(strobe.shift),
        .funcD  (funcNext[i]),
        .scanD  (scanIn),
        .q      (regQ[i])
      );
    end else begin : g_body
      scan_cell u_cell (
        .clk    (clk),
        .rstN   (rstN),
        .testSel(strobe.shift),
        .funcD  (funcNext[i]),
        .scanD  (regQ[i-1]),
        .q      (regQ[i])
      );
    end
  end

  // Output tap at the active chain end
  logic tapBit;
  always_comb begin
    tapBit = regQ[MAX_LEN-1];
    for (int i = 0; i < MAX_LEN; i++) begin
      if (LEN_W'(i + 1) == chainLen) tapBit = regQ[i];
    end
  end

  assign scanOut = tapBit;

  // Sticky comparator
  logic mismatch;
  assign mismatch = strobe.compare && (tapBit != expIn);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 fail <= 1'b0;
    else if (strobe.clearFail) fail <= 1'b0;
    else if (mismatch)         fail <= 1'b1;
  end

endmodule

// File: rtl/scan_ctrl.sv
module scan_ctrl
  import scan_pkg::*;
#(
  parameter int LEN_W = 5,
  parameter int PAT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [LEN_W-1:0] chainLen,
  input  logic [PAT_W-1:0] patCount,
  output scanStrobe_t      strobe,
  output logic             done
);

  seqState_t        state;
  logic [LEN_W-1:0] bitCnt;
  logic [PAT_W-1:0] patLeft;
  logic             firstPass;
  logic             lastBit;
  logic             accept;

  assign lastBit = (bitCnt == chainLen - LEN_W'(1));
  assign accept  = (state == ST_IDLE) && start && (patCount != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      patLeft   <= '0;
      firstPass <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            state     <= ST_SHIFT;
            bitCnt    <= '0;
            patLeft   <= patCount;
            firstPass <= 1'b1;
          end
        end
        ST_SHIFT: begin
          if (lastBit) begin
            state  <= ST_CAPTURE;
            bitCnt <= '0;
          end else begin
            bitCnt <= bitCnt + LEN_W'(1);
          end
        end
        ST_CAPTURE: begin
          firstPass <= 1'b0;
          patLeft   <= patLeft - PAT_W'(1);
          if (patLeft == PAT_W'(1)) state <= ST_UNLOAD;
          else                      state <= ST_SHIFT;
        end
        ST_UNLOAD: begin
          if (lastBit) begin
            state  <= ST_IDLE;
            bitCnt <= '0;
            done   <= 1'b1;
          end else begin
            bitCnt <= bitCnt + LEN_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.shift     = (state == ST_SHIFT) || (state == ST_UNLOAD);
    strobe.compare   = ((state == ST_SHIFT) && !firstPass) || (state == ST_UNLOAD);
    strobe.clearFail = accept;
  end

endmodule

// File: rtl/scan_test_ctrl.sv
module scan_test_ctrl
  import scan_pkg::*;
#(
  parameter  int MAX_LEN = 16,
  parameter  int PAT_W   = 8,
  localparam int LEN_W   = $clog2(MAX_LEN + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [LEN_W-1:0]   chainLen,
  input  logic [PAT_W-1:0]   patCount,
  input  logic               scanIn,
  input  logic               expIn,
  input  logic [MAX_LEN-1:0] funcNext,
  output logic [MAX_LEN-1:0] regQ,
  output logic               testMode,
  output logic               scanOut,
  output logic               fail,
  output logic               done
);

  scanStrobe_t strobe;

  scan_ctrl #(
    .LEN_W(LEN_W),
    .PAT_W(PAT_W)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .chainLen(chainLen),
    .patCount(patCount),
    .strobe  (strobe),
    .done    (done)
  );

  scan_datapath #(
    .MAX_LEN(MAX_LEN),
    .LEN_W  (LEN_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .chainLen(chainLen),
    .scanIn  (scanIn),
    .expIn   (expIn),
    .funcNext(funcNext),
    .regQ    (regQ),
    .scanOut (scanOut),
    .fail    (fail)
  );

  assign testMode = strobe.shift;

endmodule

// File: rtl/scan_test_ctrl_chk.sv
module scan_test_ctrl_chk (
  input logic clk,
  input logic rstN,
  input logic start,
  input logic testMode,
  input logic fail,
  input logic done
);

  // R8: end pulse lasts one cycle
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8: end pulse only once shifting has stopped
  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !testMode);

  // R8: the pulse directly follows a shift cycle
  p_done_after_unload_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(testMode));

  // R7: mismatch flag persists without a new start
  p_fail_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    (fail && !start) |=> fail);

  // R4: capture gap is a single cycle
  p_capture_one_r4: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(testMode) && !done) |=> testMode);

endmodule

bind scan_test_ctrl scan_test_ctrl_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .start   (start),
  .testMode(testMode),
  .fail    (fail),
  .done    (done)
);

// File: tb/scan_test_ctrl_tb.sv
module scan_test_ctrl_tb;

  localparam int MAX_LEN = 16;
  localparam int PAT_W   = 8;
  localparam int LEN_W   = $clog2(MAX_LEN + 1);

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               start = 1'b0;
  logic [LEN_W-1:0]   chainLen = LEN_W'(MAX_LEN);
  logic [PAT_W-1:0]   patCount = '0;
  logic               scanIn = 1'b0;
  logic               expIn = 1'b0;
  logic [MAX_LEN-1:0] funcNext;
  logic [MAX_LEN-1:0] regQ;
  logic               testMode, scanOut, fail, done;

  int nVec = 0;
  int nMis = 0;
  int cycles = 0;

  always #4 clk = ~clk;  // 125 MHz

  // Model of the logic under test: each bit depends only on itself and lower bits
  function automatic logic [MAX_LEN-1:0] fLogic(input logic [MAX_LEN-1:0] v);
    logic [MAX_LEN-1:0] r;
    r[0] = ~v[0];
    for (int i = 1; i < MAX_LEN; i++) r[i] = ~(v[i] ^ v[i-1]);
    return r;
  endfunction

  assign funcNext = fLogic(regQ);

  scan_test_ctrl #(.MAX_LEN(MAX_LEN), .PAT_W(PAT_W)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .chainLen(chainLen),
    .patCount(patCount), .scanIn(scanIn), .expIn(expIn),
    .funcNext(funcNext), .regQ(regQ), .testMode(testMode),
    .scanOut(scanOut), .fail(fail), .done(done)
  );

  typedef struct {
    logic sin;
    logic want;
    logic expv;
    logic anti;  // drive the inverse of scanOut as expected bit
    logic chk;   // compare scanOut against want
    logic bad;   // expected bit deliberately wrong
  } item_t;

  item_t stimQ[$];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nVec++;
    if (!ok) begin
      nMis++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nMis);
    $finish;
  endtask

  // Watchdog
  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        nVec++;
        nMis++;
        $display("FAIL R8 watchdog expired: actual %0d expected %0d", cycles, 0);
        finishRun();
      end
    end
  end

  // Monitor / shift driver: consumes the scoreboard queue while shifting
  initial begin
    bit pendBad = 0;
    forever begin
      @(negedge clk);
      if (pendBad) begin
        check(fail == 1'b1, "R7", "fail rise after mismatch", int'(fail), 1);
        pendBad = 0;
      end
      if (rstN && testMode) begin
        if (stimQ.size() == 0) begin
          check(1'b0, "R5", "unexpected shift cycle", 1, 0);
          scanIn = 1'b0;
          expIn  = 1'b0;
        end else begin
          item_t it;
          it = stimQ.pop_front();
          scanIn = it.sin;
          expIn  = it.anti ? ~scanOut : it.expv;
          if (it.chk)
            check(scanOut == it.want, "R5", "unloaded bit", int'(scanOut), int'(it.want));
          if (it.bad) pendBad = 1;
        end
      end else begin
        scanIn = 1'b0;
        expIn  = 1'b0;
      end
    end
  end

  // Driver: builds the expected stream and runs one test
  task automatic runTest(input int L, input int P, input int badPass,
                         input int badBit, input bit midStart, input bit expFail);
    logic [MAX_LEN-1:0] pats[8];
    logic [MAX_LEN-1:0] resp;
    int T, n;
    for (int p = 0; p < P; p++) pats[p] = MAX_LEN'($urandom);
    for (int p = 0; p <= P; p++) begin
      for (int k = 0; k < L; k++) begin
        item_t it;
        it.sin  = (p < P) ? pats[p][L-1-k] : 1'b0;
        it.anti = (p == 0);
        it.chk  = (p != 0);
        it.bad  = 1'b0;
        if (p != 0) begin
          resp    = fLogic(pats[p-1]);
          it.want = resp[L-1-k];
        end else begin
          it.want = 1'b0;
        end
        it.expv = it.want;
        if (p == badPass && k == badBit) begin
          it.expv = ~it.want;
          it.bad  = 1'b1;
        end
        stimQ.push_back(it);
      end
    end
    T = P * (L + 1) + L;
    chainLen = LEN_W'(L);
    patCount = PAT_W'(P);
    start = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
      start = midStart && (n == 3);  // R9: start while busy
      if (n == 1) check(testMode == 1'b1, "R3", "testMode after start", int'(testMode), 1);
    end while (!done && n < 2000);
    check(n == T + 1, "R8", "cycles to done", n, T + 1);
    check(stimQ.size() == 0, "R5", "scan items left over", stimQ.size(), 0);
    check(fail == expFail, "R7", "fail at done", int'(fail), int'(expFail));
    @(negedge clk);
    check(done == 1'b0, "R8", "done pulse width", int'(done), 0);
    check(testMode == 1'b0, "R9", "idle after run", int'(testMode), 0);
  endtask

  initial begin
    logic [MAX_LEN-1:0] prev;
    // R1: reset state
    #3;
    check(testMode == 0 && done == 0 && fail == 0, "R1", "outputs during reset",
          {testMode, done, fail}, 0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(testMode == 0 && done == 0 && fail == 0, "R1", "outputs after reset",
          {testMode, done, fail}, 0);

    // R2: functional mode while idle
    for (int c = 0; c < 3; c++) begin
      prev = regQ;
      @(negedge clk);
      check(regQ == fLogic(prev), "R2", "idle functional load", int'(regQ), int'(fLogic(prev)));
    end

    // R3 R4 R5 R6 R8 R9: full chain, clean run, busy start injected
    runTest(16, 3, -1, 0, 1'b1, 1'b0);
    // R7 R10: short chain with one wrong expected bit
    runTest(5, 2, 1, 2, 1'b0, 1'b1);

    // R9: start with zero patterns is ignored and fail is kept
    patCount = '0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (2) begin
      check(testMode == 1'b0, "R9", "zero-pattern start", int'(testMode), 0);
      @(negedge clk);
    end
    check(fail == 1'b1, "R9", "fail kept after ignored start", int'(fail), 1);

    // R7 R10: accepted start clears fail; single-cell chain
    runTest(1, 1, -1, 0, 1'b0, 1'b0);
    // R10: odd length, more patterns, wrong bit in final unload
    runTest(7, 4, 4, 6, 1'b0, 1'b1);
    runTest(7, 4, -1, 0, 1'b0, 1'b0);

    repeat (2) @(negedge clk);
    finishRun();
  end

endmodule